// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames from a line that rests high. A falling edge starts a frame. A baud tick running at sixteen times the bit rate paces the sampling. The block checks that the start bit is real, then takes eight data bits least significant first. An optional parity bit follows if parity is enabled, and then one stop bit. The finished word moves from a shift register into a holding register that software reads.

Four sticky status flags report the receiver state: data ready, overrun, parity error and framing error. Each kind of error decides for itself whether the new word reaches the holding register. An overrun throws the new word away and keeps the old one. A parity error or a framing error still delivers the word, but does not mark it ready. Two level interrupt outputs come from the flags: one for received data and one for any error. A single enable gates both. Software drops data-ready with a read strobe, and clears each error flag with its own strobe.

Top module: `async_rx`

## Requirements
- R1: After reset, every flag and both interrupt outputs are 0 and the holding register reads 0x00.
- R2: A frame is a 0 start bit, then data bits D0 to D7 with D0 first, then a parity bit if enabled, then a stop bit of 1. A clean frame loads the word into the holding register and sets data-ready.
- R3: When parity is disabled, the stop bit comes straight after D7, so a 10-bit frame is received correctly.
- R4: Parity is even when the odd-select input is 0 and odd when it is 1, counted over D0..D7 and the parity bit. On a mismatch the parity-error flag is set and the word is still loaded, but data-ready stays 0.
- R5: A stop bit sampled as 0 sets the framing-error flag and still loads the word. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: If a frame completes while data-ready is still 1, the overrun flag is set and the holding register keeps its previous word. The parity and framing flags are left unchanged by that frame.
- R7: A read strobe clears data-ready. If the read comes before the next frame completes, back-to-back frames are received with no overrun.
- R8: A low pulse shorter than half a bit is rejected as noise. No flag changes, and the next real frame is received correctly.
- R9: Error flags stay set until their own clear strobe. Reception continues while they are set, and a clear strobe affects only its own flag.
- R10: The receive interrupt is data-ready AND enable. The error interrupt is (overrun OR parity error OR framing error) AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| par_en_i | input | 1 | 1: a parity bit follows D7 |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| rx_ie_i | input | 1 | Enable for both interrupt outputs |
| rd_i | input | 1 | Read strobe, clears data-ready |
| clr_ovr_i | input | 1 | Clears the overrun flag |
| clr_per_i | input | 1 | Clears the parity-error flag |
| clr_fer_i | input | 1 | Clears the framing-error flag |
| rx_data_o | output | 8 | Holding register |
| rdy_o | output | 1 | Data-ready flag |
| ovr_o | output | 1 | Overrun flag |
| per_o | output | 1 | Parity-error flag |
| fer_o | output | 1 | Framing-error flag |
| rxi_o | output | 1 | Receive interrupt (level) |
| eri_o | output | 1 | Error interrupt (level) |

## Verification
The tests send words with asymmetric bit patterns (0xA5, 0x3C, 0x81 and others). A reversed bit order or a shifted frame would therefore show up as a wrong byte. Frames are sent with parity disabled, with even parity and with odd parity, each with both correct and corrupted parity bits. This separates a parity check against the wrong polarity from a correct one. A zero stop bit, an unread word followed by a second frame, and a short low glitch each trigger exactly one of the error paths. The checks then confirm which flag rose and whether the holding register changed. Repeating a parity error with the enable low shows that the interrupts follow the flags only through the enable.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK
  } rx_state_e;
endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;
  logic              done_q, perr_q, ferr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      shreg  <= '0;
      done_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        cnt <= cnt + CW'(1);
        case (st)
          S_IDLE: begin
            cnt <= '0;
            if (!rxd_i) st <= S_START;
          end
          S_START: if (cnt == MID) begin  // start must still be low mid-bit
            cnt    <= '0;
            bidx   <= '0;
            perr_q <= 1'b0;
            st     <= rxd_i ? S_IDLE : S_DATA;
          end
          S_DATA: if (cnt == LAST) begin
            cnt   <= '0;
            shreg <= {rxd_i, shreg[DATA_W-1:1]};
            if (bidx == BW'(DATA_W-1)) st <= par_en_i ? S_PAR : S_STOP;
            else                       bidx <= bidx + BW'(1);
          end
          S_PAR: if (cnt == LAST) begin
            cnt    <= '0;
            perr_q <= ((^shreg) ^ rxd_i) != par_odd_i;
            st     <= S_STOP;
          end
          S_STOP: if (cnt == LAST) begin
            cnt    <= '0;
            done_q <= 1'b1;
            ferr_q <= !rxd_i;
            st     <= rxd_i ? S_IDLE : S_BRK;
          end
          S_BRK: begin  // wait for mark before hunting again
            cnt <= '0;
            if (rxd_i) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign word_o = shreg;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_brk_waits_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_BRK && !rxd_i) |=> st == S_BRK);
endmodule

// File: rtl/async_rx_status.sv
module async_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              rd_i,
  input  logic              clr_ovr_i,
  input  logic              clr_per_i,
  input  logic              clr_fer_i,
  input  logic              ie_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              ovr_o,
  output logic              per_o,
  output logic              fer_o,
  output logic              rxi_o,
  output logic              eri_o
);
  logic [DATA_W-1:0] data_q;
  logic rdy_q, ovr_q, per_q, fer_q;
  logic accept, overrun;

  assign overrun = done_i && rdy_q;
  assign accept  = done_i && !rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      per_q  <= 1'b0;
      fer_q  <= 1'b0;
    end else begin
      if (accept) data_q <= word_i;

      if (accept && !perr_i && !ferr_i) rdy_q <= 1'b1;
      else if (rd_i)                    rdy_q <= 1'b0;

      if (overrun)        ovr_q <= 1'b1;
      else if (clr_ovr_i) ovr_q <= 1'b0;

      if (accept && perr_i) per_q <= 1'b1;
      else if (clr_per_i)   per_q <= 1'b0;

      if (accept && ferr_i) fer_q <= 1'b1;
      else if (clr_fer_i)   fer_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign rdy_o  = rdy_q;
  assign ovr_o  = ovr_q;
  assign per_o  = per_q;
  assign fer_o  = fer_q;
  assign rxi_o  = rdy_q && ie_i;
  assign eri_o  = (ovr_q || per_q || fer_q) && ie_i;

  assert_overrun_keeps_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rdy_q) |=> $stable(data_q));

  assert_error_word_loaded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !rdy_q) |=> data_q == $past(word_i));

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> !rdy_q);

  assert_per_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q && !clr_per_i) |=> per_q);

  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |-> (!rxi_o && !eri_o));
endmodule

// File: rtl/async_rx.sv
module async_rx #(
  parameter int DATA_W     = 8,
  parameter int OSR        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              baud_tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rx_ie_i,
  input  logic              rd_i,
  input  logic              clr_ovr_i,
  input  logic              clr_per_i,
  input  logic              clr_fer_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rdy_o,
  output logic              ovr_o,
  output logic              per_o,
  output logic              fer_o,
  output logic              rxi_o,
  output logic              eri_o
);
  logic              rxd_s, done, perr, ferr;
  logic [DATA_W-1:0] word;

  async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
  );

  async_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(baud_tick_i), .rxd_i(rxd_s),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .done_o(done), .word_o(word), .perr_o(perr), .ferr_o(ferr)
  );

  async_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .word_i(word),
    .perr_i(perr), .ferr_i(ferr), .rd_i(rd_i),
    .clr_ovr_i(clr_ovr_i), .clr_per_i(clr_per_i), .clr_fer_i(clr_fer_i),
    .ie_i(rx_ie_i), .data_o(rx_data_o), .rdy_o(rdy_o), .ovr_o(ovr_o),
    .per_o(per_o), .fer_o(fer_o), .rxi_o(rxi_o), .eri_o(eri_o)
  );
endmodule

// File: tb/async_rx_test.sv
module async_rx_test;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b0;
  logic par_en = 1'b1, par_odd = 1'b0, ie = 1'b1;
  logic rd = 1'b0, clr_ovr = 1'b0, clr_per = 1'b0, clr_fer = 1'b0;
  logic [7:0] data;
  logic rdy, ovr, per, fer, rxi, eri;
  int   n_chk = 0, n_bad = 0, div = 0, cyc = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    div  <= (div == TICK_DIV-1) ? 0 : div + 1;
    tick <= (div == TICK_DIV-1);
    cyc  <= cyc + 1;
    if (cyc == 200000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  async_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .baud_tick_i(tick),
    .par_en_i(par_en), .par_odd_i(par_odd), .rx_ie_i(ie), .rd_i(rd),
    .clr_ovr_i(clr_ovr), .clr_per_i(clr_per), .clr_fer_i(clr_fer),
    .rx_data_o(data), .rdy_o(rdy), .ovr_o(ovr), .per_o(per), .fer_o(fer),
    .rxi_o(rxi), .eri_o(eri)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic stop_v);
    hold(1'b0, BIT_CLK);
    for (int i = 0; i < 8; i++) hold(d[i], BIT_CLK);
    if (par_en) hold((^d) ^ par_odd ^ bad_par, BIT_CLK);
    hold(stop_v, BIT_CLK);
    hold(1'b1, BIT_CLK + BIT_CLK/2);
  endtask

  task automatic pulse_rd();
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rdy", {7'b0, rdy}, 8'h00);
    chk("R1 flags", {5'b0, ovr, per, fer}, 8'h00);
    chk("R1 irq", {6'b0, rxi, eri}, 8'h00);
    chk("R1 data", data, 8'h00);
  endtask

  task automatic t_clean_even();
    par_en = 1'b1; par_odd = 1'b0;
    send(8'hA5, 1'b0, 1'b1);
    chk("R2 data", data, 8'hA5);
    chk("R2 rdy", {7'b0, rdy}, 8'h01);
    chk("R10 rxi", {6'b0, rxi, eri}, 8'h02);
    pulse_rd();
    chk("R7 rdy cleared", {7'b0, rdy}, 8'h00);
  endtask

  task automatic t_no_parity();
    par_en = 1'b0;
    send(8'h3C, 1'b0, 1'b1);
    chk("R3 data", data, 8'h3C);
    chk("R3 flags", {4'b0, rdy, ovr, per, fer}, 8'h08);
    pulse_rd();
    par_en = 1'b1;
  endtask

  task automatic t_odd_parity();
    par_odd = 1'b1;
    send(8'h81, 1'b0, 1'b1);
    chk("R4 odd ok", {4'b0, rdy, ovr, per, fer}, 8'h08);
    pulse_rd();
    send(8'h5A, 1'b1, 1'b1);
    chk("R4 odd bad flags", {4'b0, rdy, ovr, per, fer}, 8'h02);
    chk("R4 word delivered", data, 8'h5A);
    chk("R10 eri", {6'b0, rxi, eri}, 8'h01);
    par_odd = 1'b0;
  endtask

  task automatic t_sticky();
    send(8'h11, 1'b0, 1'b1);
    chk("R9 rx continues", data, 8'h11);
    chk("R9 per stays", {4'b0, rdy, ovr, per, fer}, 8'h0A);
    clr_fer = 1'b1; @(negedge clk); clr_fer = 1'b0; @(negedge clk);
    chk("R9 other strobe", {7'b0, per}, 8'h01);
    clr_per = 1'b1; @(negedge clk); clr_per = 1'b0; @(negedge clk);
    chk("R9 cleared", {7'b0, per}, 8'h00);
    pulse_rd();
  endtask

  task automatic t_framing();
    send(8'h77, 1'b0, 1'b0);
    chk("R5 flags", {4'b0, rdy, ovr, per, fer}, 8'h01);
    chk("R5 word", data, 8'h77);
    send(8'h24, 1'b0, 1'b1);
    chk("R5 resync", data, 8'h24);
    clr_fer = 1'b1; @(negedge clk); clr_fer = 1'b0; @(negedge clk);
    pulse_rd();
  endtask

  task automatic t_overrun();
    send(8'h42, 1'b0, 1'b1);
    send(8'h99, 1'b1, 1'b0);
    chk("R6 ovr", {4'b0, rdy, ovr, per, fer}, 8'h0C);
    chk("R6 word kept", data, 8'h42);
    pulse_rd();
    clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0; @(negedge clk);
    chk("R6 cleared", {5'b0, ovr, per, fer}, 8'h00);
  endtask

  task automatic t_glitch();
    hold(1'b0, 2 * TICK_DIV);
    hold(1'b1, 2 * BIT_CLK);
    chk("R8 no frame", {4'b0, rdy, ovr, per, fer}, 8'h00);
    send(8'hC3, 1'b0, 1'b1);
    chk("R8 next frame", data, 8'hC3);
    pulse_rd();
  endtask

  task automatic t_irq_gate();
    ie = 1'b0;
    send(8'h0F, 1'b1, 1'b1);
    chk("R10 gated", {5'b0, per, rxi, eri}, 8'h04);
    ie = 1'b1; @(negedge clk);
    chk("R10 enabled", {6'b0, rxi, eri}, 8'h01);
    clr_per = 1'b1; @(negedge clk); clr_per = 1'b0; @(negedge clk);
  endtask

  task automatic t_back_to_back();
    send(8'h6E, 1'b0, 1'b1);
    pulse_rd();
    send(8'hD1, 1'b0, 1'b1);
    chk("R7 second word", data, 8'hD1);
    chk("R7 no overrun", {4'b0, rdy, ovr, per, fer}, 8'h08);
    pulse_rd();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_clean_even();
    t_no_parity();
    t_odd_parity();
    t_sticky();
    t_framing();
    t_overrun();
    t_glitch();
    t_irq_gate();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule